// File: doc/BRIEF.md
# Multi-Window Address Decoder with Translation

This block sits at the address path of a bus bridge. It checks each incoming 32-bit address against six programmable windows. Each window holds a base value, a mask, an access-space flag (memory or IO), a replacement value and a replacement enable. Only the top `DEC_W` address bits take part in the comparison, so the smallest window is 2^(32-`DEC_W`) bytes. For example, 24 bits give 256-byte windows, 20 bits give 4 KB windows and a single bit gives 2 GB windows.

The block returns three results: a hit flag, a one-hot window select and the outgoing address. On a hit to a window whose replacement is enabled, the masked upper bits of the outgoing address come from that window's replacement value. Window settings are loaded from parameter values at reset. A direct parallel write port changes them afterwards. The decode delay is fixed at build time to one, two or three clocks, which gives slow targets more time to settle the compare.

Top module: `win_decoder`

## Requirements
- R1: Only address bits [31:32-DEC_W] are compared. The lower bits never change the hit or select outputs, and they always pass to `rsp_addr` unchanged.
- R2: A window matches when the address and its base agree on every compared bit where the window's mask bit is 1.
- R3: A window with an all-zero mask never matches. All masks reset to zero by default, so every request misses after reset.
- R4: A match also needs `req_io` to equal the window's space flag, where 0 means memory and 1 means IO.
- R5: `cfg_err[i]` is 1 while window i is present, its mask has every compared bit set, and its space flag is 0 (memory).
- R6: With `XLAT_BUILT`=1 and a hit on a window whose enable is 1, `rsp_addr` takes the masked upper bits from that window's replacement value. The unmasked upper bits and the low bits come from the request.
- R7: With `XLAT_BUILT`=0, with the hit window's enable at 0, or on a miss, `rsp_addr` equals the request address.
- R8: `rsp_valid` pulses for one cycle exactly `SPEED` cycles (1, 2 or 3) after the edge that samples `req_valid`. Back-to-back requests give back-to-back responses in order.
- R9: Window 1 is always present. Windows 0 and 2 to 5 are present only when their bit of `PRESENT` is 1. An absent window never matches, writes to it have no effect, and its `cfg_err` bit stays 0.
- R10: When several windows match, the lowest-numbered one wins. `rsp_sel` is one-hot on a hit and all zeros on a miss, and `rsp_hit` is 1 exactly when `rsp_sel` is nonzero.
- R11: `rsp_hit`, `rsp_sel` and `rsp_addr` are registered. They change only together with a `rsp_valid` pulse, and synchronous `rst` clears them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for one window's settings |
| cfg_idx | input | 3 | Window number to write |
| cfg_base | input | DEC_W | Base value (compared upper bits) |
| cfg_mask | input | DEC_W | Mask; 1 = bit takes part |
| cfg_io | input | 1 | Space flag: 0 memory, 1 IO |
| cfg_xlat | input | DEC_W | Replacement value for masked upper bits |
| cfg_xen | input | 1 | Replacement enable |
| req_valid | input | 1 | Request strobe |
| req_io | input | 1 | Request space: 0 memory, 1 IO |
| req_addr | input | ADDR_W | Request address |
| rsp_valid | output | 1 | Result strobe, SPEED cycles after request |
| rsp_hit | output | 1 | Some window matched |
| rsp_sel | output | 6 | One-hot winning window |
| rsp_addr | output | ADDR_W | Outgoing (possibly replaced) address |
| cfg_err | output | 6 | Per-window illegal full-mask memory setting |

## Verification
The bench uses overlapping windows: a wide window 0 covering a narrower window 1. A decoder that gives priority to the highest number, or that ORs the selects together, would report window 1 or a two-hot select. It sends the same address as memory and as IO, which catches a decoder that ignores the space flag. It varies only the low byte against a full-mask IO window, which catches a compare that reaches below the decoded bits. It programs a window that the build leaves absent and expects a miss and no error flag from it. A second instance built without replacement and with three-cycle delay must pass the address through even with the enable set, and each response's arrival cycle is checked against its request. A mis-sized delay chain would shift that arrival cycle, and a result register that loads on every cycle would break the hold checks made between responses.

// File: rtl/win_dec_pkg.sv
package win_dec_pkg;
  localparam int IMG_COUNT  = 6;
  localparam int IDX_W      = $clog2(IMG_COUNT);
  localparam int ALWAYS_IMG = 1;

  typedef logic [IMG_COUNT-1:0] img_vec_t;

  typedef enum int {
    DEC_FAST   = 1,
    DEC_MEDIUM = 2,
    DEC_SLOW   = 3
  } dec_speed_e;

  // Keep only the lowest set bit of a match vector.
  function automatic img_vec_t first_hit(input img_vec_t v);
    img_vec_t r;
    r = '0;
    for (int i = IMG_COUNT - 1; i >= 0; i--) begin
      if (v[i]) r = img_vec_t'(1) << i;
    end
    return r;
  endfunction
endpackage

// File: rtl/win_dec_regs.sv
module win_dec_regs
  import win_dec_pkg::*;
#(
  parameter int       DEC_W    = 24,
  parameter img_vec_t LIVE     = '1,
  parameter logic [IMG_COUNT*DEC_W-1:0] RST_BASE = '0,
  parameter logic [IMG_COUNT*DEC_W-1:0] RST_MASK = '0,
  parameter logic [IMG_COUNT*DEC_W-1:0] RST_XLAT = '0,
  parameter img_vec_t RST_IO   = '0,
  parameter img_vec_t RST_XEN  = '0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [DEC_W-1:0]           wr_base,
  input  logic [DEC_W-1:0]           wr_mask,
  input  logic                       wr_io,
  input  logic [DEC_W-1:0]           wr_xlat,
  input  logic                       wr_xen,
  output logic [IMG_COUNT*DEC_W-1:0] base_o,
  output logic [IMG_COUNT*DEC_W-1:0] mask_o,
  output logic [IMG_COUNT*DEC_W-1:0] xlat_o,
  output img_vec_t                   io_o,
  output img_vec_t                   xen_o,
  output img_vec_t                   err_o
);

  for (genvar i = 0; i < IMG_COUNT; i++) begin : g_img
    if (LIVE[i]) begin : g_live
      logic [DEC_W-1:0] base_q, mask_q, xlat_q;
      logic             io_q, xen_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          base_q <= RST_BASE[i*DEC_W +: DEC_W];
          mask_q <= RST_MASK[i*DEC_W +: DEC_W];
          xlat_q <= RST_XLAT[i*DEC_W +: DEC_W];
          io_q   <= RST_IO[i];
          xen_q  <= RST_XEN[i];
        end else if (wr_en && wr_idx == IDX_W'(i)) begin
          base_q <= wr_base;
          mask_q <= wr_mask;
          xlat_q <= wr_xlat;
          io_q   <= wr_io;
          xen_q  <= wr_xen;
        end
      end

      assign base_o[i*DEC_W +: DEC_W] = base_q;
      assign mask_o[i*DEC_W +: DEC_W] = mask_q;
      assign xlat_o[i*DEC_W +: DEC_W] = xlat_q;
      assign io_o[i]  = io_q;
      assign xen_o[i] = xen_q;
      assign err_o[i] = (&mask_q) & ~io_q;
    end else begin : g_absent
      assign base_o[i*DEC_W +: DEC_W] = '0;
      assign mask_o[i*DEC_W +: DEC_W] = '0;
      assign xlat_o[i*DEC_W +: DEC_W] = '0;
      assign io_o[i]  = 1'b0;
      assign xen_o[i] = 1'b0;
      assign err_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/win_dec_match.sv
module win_dec_match #(
  parameter int DEC_W      = 24,
  parameter bit XLAT_BUILT = 1'b1
) (
  input  logic [DEC_W-1:0] up,
  input  logic             acc_io,
  input  logic [DEC_W-1:0] base,
  input  logic [DEC_W-1:0] mask,
  input  logic             img_io,
  input  logic [DEC_W-1:0] xlat,
  input  logic             xen,
  output logic             hit,
  output logic [DEC_W-1:0] xup
);

  logic use_x;

  always_comb begin
    hit   = (|mask) && (((up ^ base) & mask) == '0) && (acc_io == img_io);
    use_x = XLAT_BUILT && xen;
    xup   = use_x ? ((xlat & mask) | (up & ~mask)) : up;
  end

endmodule

// File: rtl/win_decoder.sv
module win_decoder
  import win_dec_pkg::*;
#(
  parameter int         ADDR_W     = 32,
  parameter int         DEC_W      = 24,
  parameter img_vec_t   PRESENT    = '1,
  parameter bit         XLAT_BUILT = 1'b1,
  parameter dec_speed_e SPEED      = DEC_FAST,
  parameter logic [IMG_COUNT*DEC_W-1:0] RST_BASE = '0,
  parameter logic [IMG_COUNT*DEC_W-1:0] RST_MASK = '0,
  parameter logic [IMG_COUNT*DEC_W-1:0] RST_XLAT = '0,
  parameter img_vec_t   RST_IO     = '0,
  parameter img_vec_t   RST_XEN    = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [DEC_W-1:0]     cfg_base,
  input  logic [DEC_W-1:0]     cfg_mask,
  input  logic                 cfg_io,
  input  logic [DEC_W-1:0]     cfg_xlat,
  input  logic                 cfg_xen,
  input  logic                 req_valid,
  input  logic                 req_io,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic [IMG_COUNT-1:0] rsp_sel,
  output logic [ADDR_W-1:0]    rsp_addr,
  output logic [IMG_COUNT-1:0] cfg_err
);

  localparam int       LAT   = int'(SPEED);
  localparam int       PKT_W = ADDR_W + 2;
  localparam img_vec_t LIVE  = PRESENT | (img_vec_t'(1) << ALWAYS_IMG);

  logic [IMG_COUNT*DEC_W-1:0] r_base, r_mask, r_xlat;
  img_vec_t                   r_io, r_xen, r_err;

  win_dec_regs #(
    .DEC_W(DEC_W), .LIVE(LIVE),
    .RST_BASE(RST_BASE), .RST_MASK(RST_MASK), .RST_XLAT(RST_XLAT),
    .RST_IO(RST_IO), .RST_XEN(RST_XEN)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_base(cfg_base), .wr_mask(cfg_mask),
    .wr_io(cfg_io), .wr_xlat(cfg_xlat), .wr_xen(cfg_xen),
    .base_o(r_base), .mask_o(r_mask), .xlat_o(r_xlat),
    .io_o(r_io), .xen_o(r_xen), .err_o(r_err)
  );

  assign cfg_err = r_err;

  // Request delay: LAT-1 stages ahead of the compare, one result stage after.
  logic [PKT_W-1:0] in_pkt, d_pkt;
  assign in_pkt = {req_valid, req_io, req_addr};

  if (LAT == 1) begin : g_fast
    assign d_pkt = in_pkt;
  end else begin : g_slow
    logic [PKT_W-1:0] stg [LAT-1];
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int k = 0; k < LAT - 1; k++) stg[k] <= '0;
      end else begin
        stg[0] <= in_pkt;
        for (int k = 1; k < LAT - 1; k++) stg[k] <= stg[k-1];
      end
    end
    assign d_pkt = stg[LAT-2];
  end

  logic              d_valid, d_io;
  logic [ADDR_W-1:0] d_addr;
  logic [DEC_W-1:0]  d_up;
  assign {d_valid, d_io, d_addr} = d_pkt;
  assign d_up = d_addr[ADDR_W-1 -: DEC_W];

  img_vec_t                   hit_vec;
  logic [IMG_COUNT*DEC_W-1:0] xup_flat;

  for (genvar i = 0; i < IMG_COUNT; i++) begin : g_cmp
    win_dec_match #(.DEC_W(DEC_W), .XLAT_BUILT(XLAT_BUILT)) u_match (
      .up(d_up), .acc_io(d_io),
      .base(r_base[i*DEC_W +: DEC_W]), .mask(r_mask[i*DEC_W +: DEC_W]),
      .img_io(r_io[i]), .xlat(r_xlat[i*DEC_W +: DEC_W]), .xen(r_xen[i]),
      .hit(hit_vec[i]), .xup(xup_flat[i*DEC_W +: DEC_W])
    );
  end

  img_vec_t         win;
  logic [DEC_W-1:0] xsel;

  always_comb begin
    win  = first_hit(hit_vec);
    xsel = '0;
    for (int i = 0; i < IMG_COUNT; i++) begin
      if (win[i]) xsel = xsel | xup_flat[i*DEC_W +: DEC_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_sel   <= '0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= d_valid;
      if (d_valid) begin
        rsp_hit  <= |hit_vec;
        rsp_sel  <= win;
        rsp_addr <= d_addr;
        if (|hit_vec) rsp_addr[ADDR_W-1 -: DEC_W] <= xsel;
      end
    end
  end

  // Checks placed beside the logic they cover.
  AST_RSP_DELAY: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid, LAT)); // R8
  AST_SEL_COUNT: assert property (@(posedge clk) disable iff (rst)
    $countones(rsp_sel) == (rsp_hit ? 1 : 0)); // R10
  AST_MISS_ADDR: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> rsp_addr == $past(req_addr, LAT)); // R7
  AST_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_addr[ADDR_W-DEC_W-1:0] == $past(req_addr[ADDR_W-DEC_W-1:0], LAT)); // R1
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> ($stable(rsp_hit) && $stable(rsp_sel) && $stable(rsp_addr))); // R11
  AST_ABSENT_SEL: assert property (@(posedge clk) disable iff (rst)
    (rsp_sel & ~LIVE) == '0); // R9
  AST_CFG_FLAG: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_idx < IDX_W'(IMG_COUNT) && (&cfg_mask) && !cfg_io && LIVE[cfg_idx])
      |=> cfg_err[$past(cfg_idx)]); // R5

  if (!XLAT_BUILT) begin : g_no_xlat
    AST_PASS_ADDR: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> rsp_addr == $past(req_addr, LAT)); // R7
  end

endmodule

// File: tb/win_decoder_test.sv
module win_decoder_test;
  import win_dec_pkg::*;

  localparam int       CLK_PERIOD = 10;
  localparam int       LAT_A = 2;
  localparam int       LAT_B = 3;
  localparam img_vec_t BLD_PRES = 6'b111001;   // window 1 forced on by the block
  localparam img_vec_t EXP_PRES = 6'b111011;

  typedef struct packed {
    logic        hit;
    logic [5:0]  sel;
    logic [31:0] addr;
    logic [31:0] stamp;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_io = 1'b0, cfg_xen = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [23:0] cfg_base = '0, cfg_mask = '0, cfg_xlat = '0;
  logic        req_valid = 1'b0, req_io = 1'b0;
  logic [31:0] req_addr = '0;

  logic        a_valid, a_hit, b_valid, b_hit;
  logic [5:0]  a_sel, b_sel, a_err, b_err;
  logic [31:0] a_addr, b_addr;

  win_decoder #(.PRESENT(BLD_PRES), .XLAT_BUILT(1'b1), .SPEED(DEC_MEDIUM)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
    .cfg_mask(cfg_mask), .cfg_io(cfg_io), .cfg_xlat(cfg_xlat), .cfg_xen(cfg_xen),
    .req_valid(req_valid), .req_io(req_io), .req_addr(req_addr),
    .rsp_valid(a_valid), .rsp_hit(a_hit), .rsp_sel(a_sel), .rsp_addr(a_addr), .cfg_err(a_err));

  win_decoder #(.PRESENT(BLD_PRES), .XLAT_BUILT(1'b0), .SPEED(DEC_SLOW)) uut_pass (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
    .cfg_mask(cfg_mask), .cfg_io(cfg_io), .cfg_xlat(cfg_xlat), .cfg_xen(cfg_xen),
    .req_valid(req_valid), .req_io(req_io), .req_addr(req_addr),
    .rsp_valid(b_valid), .rsp_hit(b_hit), .rsp_sel(b_sel), .rsp_addr(b_addr), .cfg_err(b_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference window settings, built from the requirements.
  logic [23:0] m_base [6];
  logic [23:0] m_mask [6];
  logic [23:0] m_xlat [6];
  logic        m_io   [6];
  logic        m_xen  [6];

  function automatic exp_t model(input logic [31:0] a, input logic io, input bit xl);
    exp_t r;
    logic [23:0] up;
    up = a[31:8];
    r = '0;
    r.addr = a;
    for (int i = 0; i < 6; i++) begin
      if (!r.hit && EXP_PRES[i] && m_mask[i] != 0 &&
          ((up ^ m_base[i]) & m_mask[i]) == 0 && io == m_io[i]) begin
        r.hit = 1'b1;
        r.sel = 6'(1) << i;
        if (xl && m_xen[i]) r.addr[31:8] = (m_xlat[i] & m_mask[i]) | (up & ~m_mask[i]);
      end
    end
    return r;
  endfunction

  exp_t  qa[$], qb[$];
  string ta[$], tb[$];
  exp_t  last_a;

  task automatic set_win(input int idx, input logic [23:0] b, input logic [23:0] m,
                         input logic io, input logic [23:0] x, input logic xe);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_base = b; cfg_mask = m;
    cfg_io = io; cfg_xlat = x; cfg_xen = xe;
    if (EXP_PRES[idx]) begin
      m_base[idx] = b; m_mask[idx] = m; m_io[idx] = io; m_xlat[idx] = x; m_xen[idx] = xe;
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [31:0] a, input logic io, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_io = io;
    e = model(a, io, 1'b1); e.stamp = cyc; qa.push_back(e); ta.push_back(tag);
    e = model(a, io, 1'b0); e.stamp = cyc; qb.push_back(e); tb.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: pop and compare as results appear.
  always @(negedge clk) begin
    if (!rst) begin
      if (a_valid) begin
        if (qa.size() == 0) check(1'b0, "R8 unexpected response (translating)", 64'(a_addr), 64'(0));
        else begin
          exp_t e; string t;
          e = qa.pop_front(); t = ta.pop_front();
          check(a_hit == e.hit, {t, " hit"}, 64'(a_hit), 64'(e.hit));
          check(a_sel == e.sel, {t, " sel"}, 64'(a_sel), 64'(e.sel));
          check(a_addr == e.addr, {t, " addr"}, 64'(a_addr), 64'(e.addr));
          check(cyc - e.stamp == LAT_A, "R8 delay (translating)", 64'(cyc - e.stamp), 64'(LAT_A));
          last_a = e;
        end
      end
      if (b_valid) begin
        if (qb.size() == 0) check(1'b0, "R8 unexpected response (pass-through)", 64'(b_addr), 64'(0));
        else begin
          exp_t e; string t;
          e = qb.pop_front(); t = tb.pop_front();
          check(b_hit == e.hit, {t, " hit (pass-through)"}, 64'(b_hit), 64'(e.hit));
          check(b_sel == e.sel, {t, " sel (pass-through)"}, 64'(b_sel), 64'(e.sel));
          check(b_addr == e.addr, {t, " R7 addr (pass-through)"}, 64'(b_addr), 64'(e.addr));
          check(cyc - e.stamp == LAT_B, "R8 delay (pass-through)", 64'(cyc - e.stamp), 64'(LAT_B));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) begin
      m_base[i] = '0; m_mask[i] = '0; m_xlat[i] = '0; m_io[i] = 1'b0; m_xen[i] = 1'b0;
    end
    last_a = '0;
    repeat (3) @(negedge clk);
    check(a_valid == 0 && a_hit == 0 && a_sel == 0 && a_addr == 0, "R11 reset outputs",
          64'({a_valid, a_hit, a_sel}), 64'(0));
    check(a_err == 0, "R5 reset error flags", 64'(a_err), 64'(0));
    rst = 1'b0;

    // R3: every mask is zero after reset
    send(32'h8000_0000, 1'b0, "R3 empty masks");
    send(32'h0000_0000, 1'b1, "R3 empty masks io");
    idle(5);

    // R2 / R4 / R7: window 1, memory, no replacement
    set_win(1, 24'h800000, 24'hFF0000, 1'b0, 24'hABCDEF, 1'b0);
    send(32'h8012_3456, 1'b0, "R2 masked hit");
    send(32'h8112_3456, 1'b0, "R2 masked miss");
    send(32'h8012_3456, 1'b1, "R4 space mismatch");
    idle(5);
    check(a_hit == 1'b0 && a_sel == 0, "R4 io access to memory window", 64'(a_sel), 64'(0));

    // R1: full-mask IO window, low byte is free
    set_win(5, 24'h123456, 24'hFFFFFF, 1'b1, 24'h0, 1'b0);
    check(a_err == 0, "R5 full mask on IO window", 64'(a_err), 64'(0));
    send(32'h1234_56AB, 1'b1, "R1 low byte ignored");
    send(32'h1234_5600, 1'b1, "R1 low byte zero");
    send(32'h1234_5700, 1'b1, "R1 next window miss");
    idle(5);

    // R10: window 0 overlaps window 1
    set_win(0, 24'h800000, 24'h800000, 1'b0, 24'h0, 1'b0);
    send(32'h8012_3456, 1'b0, "R10 lowest wins");
    idle(5);
    check(a_sel == 6'b000001, "R10 overlap select", 64'(a_sel), 64'(6'b000001));

    // R9: window 2 absent
    set_win(2, 24'h200000, 24'hFFFFFF, 1'b0, 24'h0, 1'b0);
    check(a_err[2] == 1'b0, "R9 absent window error flag", 64'(a_err), 64'(0));
    send(32'h2000_0010, 1'b0, "R9 absent window");
    idle(5);

    // R6: replacement on window 3
    set_win(3, 24'h400000, 24'hFFFF00, 1'b0, 24'h123477, 1'b1);
    send(32'h4000_0A5C, 1'b0, "R6 replacement");
    idle(6);
    check(a_addr == 32'h1234_0A5C, "R6 replaced address", 64'(a_addr), 64'(32'h1234_0A5C));
    check(b_addr == 32'h4000_0A5C, "R7 no replacement built", 64'(b_addr), 64'(32'h4000_0A5C));
    set_win(3, 24'h400000, 24'hFFFF00, 1'b0, 24'h123477, 1'b0);
    send(32'h4000_0B00, 1'b0, "R7 replacement disabled");
    idle(5);

    // R5: memory window with full mask
    set_win(4, 24'h0000F0, 24'hFFFFFF, 1'b0, 24'h0, 1'b0);
    check(a_err == 6'b010000, "R5 full mask memory window", 64'(a_err), 64'(6'b010000));
    set_win(4, 24'h0000F0, 24'hFFFFFF, 1'b1, 24'h0, 1'b0);
    check(a_err == 6'b000000, "R5 flag clears for IO", 64'(a_err), 64'(0));

    // R8: back-to-back stream
    send(32'h8012_3456, 1'b0, "R8 stream 0");
    send(32'h1234_5601, 1'b1, "R8 stream 1");
    send(32'h4000_0C00, 1'b0, "R8 stream 2");
    send(32'h0000_F000, 1'b1, "R8 stream 3");
    send(32'h7000_0000, 1'b0, "R8 stream 4");
    idle(6);

    // R11: outputs hold between responses
    check(a_hit == last_a.hit && a_sel == last_a.sel && a_addr == last_a.addr,
          "R11 hold after response", 64'(a_addr), 64'(last_a.addr));
    idle(4);
    check(a_addr == last_a.addr && a_sel == last_a.sel, "R11 hold while idle",
          64'(a_addr), 64'(last_a.addr));

    check(qa.size() == 0 && qb.size() == 0, "R8 all responses arrived",
          64'(qa.size() + qb.size()), 64'(0));

    // R11: synchronous reset clears results
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(a_valid == 0 && a_hit == 0 && a_sel == 0 && a_addr == 0, "R11 reset clears",
          64'(a_addr), 64'(0));
    check(a_err == 0, "R3 reset clears masks", 64'(a_err), 64'(0));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule